// File: doc/BRIEF.md
# Accumulator Single-Bus Datapath

This block is the data half of a small accumulator machine. It holds a 16-bit accumulator, an 11-bit program counter, an 11-bit memory address register, a 16-bit memory buffer register and a 5-bit instruction register. It performs no sequencing of its own. An external controller drives a 19-bit control word every clock. That word picks the sources for two ALU input buses, selects one ALU function, and names the registers that capture the result bus on the next rising edge.

Memory sits outside the block. The address register drives the memory address, and the buffer register drives the write data. The read and write strobes come straight from the control word. When a source enable is left off, its bus carries zero. Because of this, the ADD function also serves as a move (one source only) and as a clear (no source). The controller receives two status flags: accumulator zero and accumulator negative.

Top module: `acc_datapath`

## Requirements
- R1: An active-low reset clears AC, PC, MAR, MBR and IR to zero.
- R2: Control bit 18 puts AC, bit 17 puts PC and bit 16 puts MAR on the first ALU input. PC and MAR are zero-extended. With none of these bits set, the first input is zero.
- R3: Control bit 15 puts MBR on the second ALU input, and bit 14 puts the constant 1 there. With neither bit set, the second input is zero.
- R4: Bit 13 selects first+second and bit 12 selects first−second, both modulo 2^16.
- R5: Bit 11 selects the bitwise AND of the two inputs, and bit 10 selects their bitwise OR.
- R6: Bits 9, 8 and 7 select shifts of the first input by one place: left with zero fill, right with zero fill, and right with the sign bit copied in.
- R7: When none of bits 13 to 7 is set, the result bus is zero.
- R8: On a rising edge, the result is captured by AC if bit 6 is set, by PC (result 10:0) if bit 5 is set, by MBR if bit 4 is set, by MAR (result 10:0) if bit 3 is set, and by IR (result 15:11) if bit 0 is set. Any combination of these may be set together. A register whose bit is clear keeps its value.
- R9: When bit 2 (read) is set, MBR captures the memory read data on the edge. This read takes priority over bit 4.
- R10: The memory address output always shows MAR, and the write data output always shows MBR. The read strobe follows bit 2 and the write strobe follows bit 1 in the same cycle.
- R11: The zero flag is high exactly when AC is 0. The negative flag equals AC bit 15. Both flags are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 19 | Control word from the controller |
| mem_rdata | input | 16 | Read data from memory |
| mem_addr | output | 11 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (MBR) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ac_q | output | 16 | Accumulator |
| pc_q | output | 11 | Program counter |
| mar_q | output | 11 | Memory address register |
| mbr_q | output | 16 | Memory buffer register |
| ir_q | output | 5 | Instruction register |
| ac_zero | output | 1 | AC equals zero |
| ac_neg | output | 1 | AC bit 15 |

## Verification
Results arrive on two schedules. The strobes, the memory address and data outputs, and the two flags are combinational, so they must match in the same cycle as the control word that caused them. Every register update lands exactly one rising edge after its control word. The bench drives each control word on the falling edge. It checks the combinational outputs 1 ns later and the registers 2 ns after the following rising edge, both against a behavioural model that advances one step per clock. Directed words cover each source, function and load combination. A seeded pseudo-random stream then mixes them.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  localparam int CTRL_W = 19;

  typedef struct packed {
    logic s1_ac;
    logic s1_pc;
    logic s1_mar;
    logic s2_mbr;
    logic s2_one;
    logic f_add;
    logic f_sub;
    logic f_and;
    logic f_or;
    logic f_shl;
    logic f_shr;
    logic f_ashr;
    logic ld_ac;
    logic ld_pc;
    logic ld_mbr;
    logic ld_mar;
    logic mem_read;
    logic mem_write;
    logic ld_ir;
  } ctl_t;

  typedef struct packed {
    logic add;
    logic sub;
    logic band;
    logic bor;
    logic shl;
    logic shr;
    logic ashr;
  } alu_fn_t;
endpackage

// File: rtl/acc_dp_srcsel.sv
module acc_dp_srcsel #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_ac,
  input  logic              sel_pc,
  input  logic              sel_mar,
  input  logic              sel_mbr,
  input  logic              sel_one,
  input  logic [DATA_W-1:0] ac,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] mar,
  input  logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] s1,
  output logic [DATA_W-1:0] s2
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] pc_ext, mar_ext, one_c;

  assign pc_ext  = {{PAD_W{1'b0}}, pc};
  assign mar_ext = {{PAD_W{1'b0}}, mar};
  assign one_c   = {{(DATA_W-1){1'b0}}, 1'b1};

  // and-or selection: an idle bus settles at zero
  assign s1 = ({DATA_W{sel_ac}}  & ac)
            | ({DATA_W{sel_pc}}  & pc_ext)
            | ({DATA_W{sel_mar}} & mar_ext);
  assign s2 = ({DATA_W{sel_mbr}} & mbr)
            | ({DATA_W{sel_one}} & one_c);

  assert_s1_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ac && !sel_pc && !sel_mar) |-> (s1 == '0));
  assert_s2_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_one && !sel_mbr) |-> (s2 == DATA_W'(1)));
endmodule

// File: rtl/acc_dp_alu.sv
module acc_dp_alu
  import acc_dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  alu_fn_t           fn,
  input  logic [DATA_W-1:0] s1,
  input  logic [DATA_W-1:0] s2,
  output logic [DATA_W-1:0] result
);
  function automatic logic [DATA_W-1:0] sum_f(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] diff_f(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic [DATA_W-1:0] shl_f(input logic [DATA_W-1:0] a);
    return {a[DATA_W-2:0], 1'b0};
  endfunction

  function automatic logic [DATA_W-1:0] shr_f(input logic [DATA_W-1:0] a);
    return {1'b0, a[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W-1:0] ashr_f(input logic [DATA_W-1:0] a);
    return {a[DATA_W-1], a[DATA_W-1:1]};
  endfunction

  logic [DATA_W-1:0] r_add, r_sub, r_and, r_or, r_shl, r_shr, r_ashr;
  logic              fn_idle;

  assign r_add  = sum_f(s1, s2);
  assign r_sub  = diff_f(s1, s2);
  assign r_and  = s1 & s2;
  assign r_or   = s1 | s2;
  assign r_shl  = shl_f(s1);
  assign r_shr  = shr_f(s1);
  assign r_ashr = ashr_f(s1);
  assign fn_idle = (fn == '0);

  always_comb begin
    result = '0;
    if (fn.add)  result = result | r_add;
    if (fn.sub)  result = result | r_sub;
    if (fn.band) result = result | r_and;
    if (fn.bor)  result = result | r_or;
    if (fn.shl)  result = result | r_shl;
    if (fn.shr)  result = result | r_shr;
    if (fn.ashr) result = result | r_ashr;
  end

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fn_idle |-> (result == '0));
  assert_shl_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(fn) && fn.shl) |-> (result[0] == 1'b0));
endmodule

// File: rtl/acc_dp_regs.sv
module acc_dp_regs #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int OP_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ac,
  input  logic              ld_pc,
  input  logic              ld_mbr,
  input  logic              ld_mar,
  input  logic              ld_ir,
  input  logic              mem_read,
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] ac,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [OP_W-1:0]   ir
);
  logic [DATA_W-1:0] mbr_next;
  logic              mbr_en;

  // a memory read wins over a bus load of MBR
  assign mbr_next = mem_read ? mem_rdata : result;
  assign mbr_en   = mem_read | ld_mbr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac  <= '0;
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
    end else begin
      if (ld_ac)  ac  <= result;
      if (ld_pc)  pc  <= result[ADDR_W-1:0];
      if (ld_mar) mar <= result[ADDR_W-1:0];
      if (ld_ir)  ir  <= result[DATA_W-1 -: OP_W];
      if (mbr_en) mbr <= mbr_next;
    end
  end

  assert_ac_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ac |=> $stable(ac));
  assert_ac_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ac |=> (ac == $past(result)));
  assert_ir_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ir |=> (ir == $past(result[DATA_W-1 -: OP_W])));
  assert_read_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_read |=> (mbr == $past(mem_rdata)));
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_dp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int OP_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] ac_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mbr_q,
  output logic [OP_W-1:0]   ir_q,
  output logic              ac_zero,
  output logic              ac_neg
);
  ctl_t              ctl;
  alu_fn_t           fn;
  logic [DATA_W-1:0] s1_bus, s2_bus, r_bus;

  assign ctl = ctl_t'(ctrl_word);
  assign fn  = '{add: ctl.f_add, sub: ctl.f_sub, band: ctl.f_and,
                 bor: ctl.f_or, shl: ctl.f_shl, shr: ctl.f_shr,
                 ashr: ctl.f_ashr};

  acc_dp_srcsel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_src (
    .clk(clk), .rst_n(rst_n),
    .sel_ac(ctl.s1_ac), .sel_pc(ctl.s1_pc), .sel_mar(ctl.s1_mar),
    .sel_mbr(ctl.s2_mbr), .sel_one(ctl.s2_one),
    .ac(ac_q), .pc(pc_q), .mar(mar_q), .mbr(mbr_q),
    .s1(s1_bus), .s2(s2_bus)
  );

  acc_dp_alu #(.DATA_W(DATA_W)) u_alu (
    .clk(clk), .rst_n(rst_n), .fn(fn),
    .s1(s1_bus), .s2(s2_bus), .result(r_bus)
  );

  acc_dp_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OP_W(OP_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ld_ac(ctl.ld_ac), .ld_pc(ctl.ld_pc), .ld_mbr(ctl.ld_mbr),
    .ld_mar(ctl.ld_mar), .ld_ir(ctl.ld_ir), .mem_read(ctl.mem_read),
    .result(r_bus), .mem_rdata(mem_rdata),
    .ac(ac_q), .pc(pc_q), .mar(mar_q), .mbr(mbr_q), .ir(ir_q)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign mem_rd    = ctl.mem_read;
  assign mem_wr    = ctl.mem_write;
  assign ac_zero   = (ac_q == '0);
  assign ac_neg    = ac_q[DATA_W-1];

  assert_mar_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ld_mar |=> $stable(mem_addr));
endmodule

// File: tb/acc_datapath_tb.sv
`timescale 1ns/1ps
module acc_datapath_tb_top;
  localparam logic [18:0] C_EAC  = 19'h1 << 18;
  localparam logic [18:0] C_EPC  = 19'h1 << 17;
  localparam logic [18:0] C_EMA  = 19'h1 << 16;
  localparam logic [18:0] C_EMB  = 19'h1 << 15;
  localparam logic [18:0] C_ONE  = 19'h1 << 14;
  localparam logic [18:0] C_ADD  = 19'h1 << 13;
  localparam logic [18:0] C_SUB  = 19'h1 << 12;
  localparam logic [18:0] C_AND  = 19'h1 << 11;
  localparam logic [18:0] C_OR   = 19'h1 << 10;
  localparam logic [18:0] C_SHL  = 19'h1 << 9;
  localparam logic [18:0] C_SHR  = 19'h1 << 8;
  localparam logic [18:0] C_ASHR = 19'h1 << 7;
  localparam logic [18:0] C_LAC  = 19'h1 << 6;
  localparam logic [18:0] C_LPC  = 19'h1 << 5;
  localparam logic [18:0] C_LMB  = 19'h1 << 4;
  localparam logic [18:0] C_LMA  = 19'h1 << 3;
  localparam logic [18:0] C_RD   = 19'h1 << 2;
  localparam logic [18:0] C_WR   = 19'h1 << 1;
  localparam logic [18:0] C_LIR  = 19'h1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] ctrl_word = '0;
  logic [15:0] mem_rdata;
  logic [10:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_rd, mem_wr;
  logic [15:0] ac_q, mbr_q;
  logic [10:0] pc_q, mar_q;
  logic [4:0]  ir_q;
  logic        ac_zero, ac_neg;

  logic [15:0] mem [0:2047];
  assign mem_rdata = mem[mem_addr];

  int total = 0, bad = 0;
  bit done = 0;
  int m_ac = 0, m_pc = 0, m_mar = 0, m_mbr = 0, m_ir = 0;
  int seed = 12345;

  always #4 clk = ~clk;

  acc_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .ac_q(ac_q), .pc_q(pc_q), .mar_q(mar_q),
    .mbr_q(mbr_q), .ir_q(ir_q), .ac_zero(ac_zero), .ac_neg(ac_neg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk({tag, " ac"},  int'(ac_q),  m_ac);
    chk({tag, " pc"},  int'(pc_q),  m_pc);
    chk({tag, " mar"}, int'(mar_q), m_mar);
    chk({tag, " mbr"}, int'(mbr_q), m_mbr);
    chk({tag, " ir"},  int'(ir_q),  m_ir);
  endtask

  task automatic step(input logic [18:0] cw, input string tag);
    int a, b, r, rd;
    @(negedge clk);
    ctrl_word = cw;
    #1;
    chk({tag, " R10 rd"},   int'(mem_rd),    int'(cw[2]));
    chk({tag, " R10 wr"},   int'(mem_wr),    int'(cw[1]));
    chk({tag, " R10 addr"}, int'(mem_addr),  m_mar);
    chk({tag, " R10 data"}, int'(mem_wdata), m_mbr);
    chk({tag, " R11 zero"}, int'(ac_zero),   (m_ac == 0) ? 1 : 0);
    chk({tag, " R11 neg"},  int'(ac_neg),    (m_ac >= 32768) ? 1 : 0);
    a = 0; b = 0; r = 0;
    if (cw[18]) a = m_ac; else if (cw[17]) a = m_pc; else if (cw[16]) a = m_mar;
    if (cw[15]) b = m_mbr; else if (cw[14]) b = 1;
    if      (cw[13]) r = (a + b) % 65536;
    else if (cw[12]) r = (a - b + 65536) % 65536;
    else if (cw[11]) r = a & b;
    else if (cw[10]) r = a | b;
    else if (cw[9])  r = (a * 2) % 65536;
    else if (cw[8])  r = a / 2;
    else if (cw[7])  r = a / 2 + ((a >= 32768) ? 32768 : 0);
    rd = int'(mem[m_mar]);
    @(posedge clk);
    if (cw[1]) mem[m_mar] = m_mbr[15:0];
    if (cw[6]) m_ac  = r;
    if (cw[5]) m_pc  = r % 2048;
    if (cw[3]) m_mar = r % 2048;
    if (cw[0]) m_ir  = r / 2048;
    if (cw[2]) m_mbr = rd; else if (cw[4]) m_mbr = r;
    #2;
    chk_regs(tag);
  endtask

  function automatic logic [18:0] rnd_word();
    logic [18:0] w;
    int v;
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    v = seed >> 4;
    w = '0;
    case (v % 4) 1: w |= C_EAC; 2: w |= C_EPC; 3: w |= C_EMA; default: ; endcase
    v = v / 4;
    case (v % 3) 1: w |= C_EMB; 2: w |= C_ONE; default: ; endcase
    v = v / 3;
    case (v % 8)
      1: w |= C_ADD; 2: w |= C_SUB; 3: w |= C_AND; 4: w |= C_OR;
      5: w |= C_SHL; 6: w |= C_SHR; 7: w |= C_ASHR; default: ;
    endcase
    v = v / 8;
    if (v[0]) w |= C_LAC;
    if (v[1]) w |= C_LPC;
    if (v[2]) w |= C_LMB;
    if (v[3]) w |= C_LMA;
    if (v[4]) w |= C_LIR;
    v = v / 32;
    case (v % 3) 1: w |= C_RD; 2: w |= C_WR; default: ;
    endcase
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'((i * 37 + 5) ^ (i << 9));
    mem[0] = 16'h9A3C;
    repeat (3) @(posedge clk);
    #2;
    chk_regs("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_regs("R1 after release");
    chk("R1 R11 zero flag", int'(ac_zero), 1);
    chk("R1 R11 neg flag", int'(ac_neg), 0);

    step(C_RD,                         "R9 read mar0");
    step(C_EMB | C_ADD | C_LAC,        "R3 mbr move");
    step(C_ONE | C_ADD | C_LPC,        "R3 constant one");
    step(C_EPC | C_ADD | C_LMA,        "R2 pc source");
    step(C_RD,                         "R9 read mar1");
    step(C_EAC | C_EMB | C_SUB | C_LAC, "R4 subtract");
    step(C_EAC | C_EMB | C_ADD | C_LAC, "R4 add");
    step(C_EAC | C_EMB | C_AND | C_LAC, "R5 and");
    step(C_EAC | C_EMB | C_OR  | C_LAC, "R5 or");
    step(C_ADD | C_LAC,                "R2 R3 clear");
    step(C_EAC | C_ONE | C_SUB | C_LAC, "R4 wrap below zero");
    step(C_EAC | C_SHR | C_LAC,        "R6 logical right");
    step(C_EAC | C_ONE | C_ADD | C_LAC, "R4 increment");
    step(C_EAC | C_ONE | C_OR  | C_LAC, "R5 or one");
    step(C_EAC | C_SHL | C_LAC,        "R6 left");
    step(C_EAC | C_ASHR | C_LAC,       "R6 arithmetic right");
    step(C_EAC | C_LAC,                "R7 no function");
    step(C_RD,                         "R9 refetch");
    step(C_EMB | C_ADD | C_LAC | C_LPC | C_LMA | C_LIR, "R8 multi load");
    step(C_EMA | C_ADD | C_LAC,        "R2 mar source");
    step(C_EPC | C_ADD | C_LMB | C_RD, "R9 read over bus load");
    step(C_EAC | C_ADD | C_LMB,        "R8 mbr load");
    step(C_WR,                         "R10 write");
    step(C_EPC | C_ONE | C_ADD,        "R8 no load holds");
    step(C_RD,                         "R9 read back");
    for (int k = 0; k < 400; k++) step(rnd_word(), "R8 mixed");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule